// File: doc/BRIEF.md
# PWM Channel Waveform Generator

This block drives one pulse-width-modulated output from a clock that is prescaled by a power of two. A counter steps through one period at each prescaled tick. The part of the period held in the duty register is spent at the inactive output level, and the remainder of the period is spent at the active level. A polarity bit chooses which logic level counts as active. Every period opens on the inactive level, and a one-cycle event marks the start of each new period so that interrupt logic can record it.

Software writes the live period and duty values directly while the channel is stopped. While the channel runs, new values go through shadow update registers, and those values reach the live registers only at the next period boundary, so no period is ever cut short. A compatibility path offers a single shared update register, and a mode bit picks whether that register targets the period or the duty value.

Top module: `pwm_chan`

## Requirements
- R1: While running, the counter advances once every 2^p clock cycles, where p is mode field bits [3:0]. A value above 10 acts as 10.
- R2: A period lasts prd ticks. The counter runs from 0 to prd-1 and then wraps. `periodEnd` is high for exactly the first clock cycle of each new period, and the counter is 0 in that cycle.
- R3: In each period the output is at the active level for (prd - duty) ticks when duty < prd, and never when duty >= prd.
- R4: When duty is nonzero, each period begins at the inactive level, and the active part comes last.
- R5: Mode bit 9 is the polarity. At 0 the active level is high; at 1 the active level is low. While the channel is stopped, the output sits at the inactive level, `running` is low, and the counter is held at 0.
- R6: A value written to the period-update or duty-update strobe does not change the running period. It becomes live at the next period boundary.
- R7: `wrSharedUpd` loads the duty shadow when mode bit 10 is 0 and the period shadow when mode bit 10 is 1. Bit 10 can be written while running.
- R8: Direct period and duty writes take effect at once while the channel is stopped and are ignored while it runs. Mode bits [3:0] and bit 9 are ignored while it runs.
- R9: After reset, `pwmOut`, `running` and `periodEnd` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rstN | input | 1 | Asynchronous reset, active low |
| chanEn | input | 1 | Channel enable; `running` follows it one cycle later |
| wrMode | input | 1 | Write strobe for the mode register (bits [3:0], 9, 10 of wrData) |
| wrPrd | input | 1 | Direct write strobe for the live period |
| wrDuty | input | 1 | Direct write strobe for the live duty (inactive ticks) |
| wrPrdUpd | input | 1 | Write strobe for the period shadow |
| wrDutyUpd | input | 1 | Write strobe for the duty shadow |
| wrSharedUpd | input | 1 | Write strobe for the shared shadow, target chosen by mode bit 10 |
| wrData | input | CNT_W | Write data for all strobes |
| pwmOut | output | 1 | Waveform output |
| running | output | 1 | High while the channel is counting |
| periodEnd | output | 1 | One-cycle pulse at the start of each period |

## Verification
A counter or prescaler that has drifted shows up at once as a wrong distance between two `periodEnd` pulses. For that reason the bench measures every period length in clock cycles. A shadow value that lands too early or too late shows up within one period as a wrong active-cycle count, either in the period where the write was made or in the period after it. A wrong polarity or start level is visible in the first sampled cycle of a period, or in the first cycle after the channel stops.

// File: rtl/pwm_chan_pkg.sv
package pwm_chan_pkg;
  localparam int PRES_HI = 3;
  localparam int POL_BIT = 9;
  localparam int TGT_BIT = 10;
  localparam int MODE_W  = TGT_BIT + 1;

  typedef struct packed {
    logic loadCfg;
    logic loadTgt;
    logic prdNow;
    logic dutyNow;
    logic prdShadow;
    logic dutyShadow;
  } chanStrobe_t;
endpackage

// File: rtl/pwm_chan_prescale.sv
module pwm_chan_prescale #(
  parameter int MAX_PRES = 10
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 run,
  input  logic [pwm_chan_pkg::PRES_HI:0] presSel,
  output logic                 tick
);
  localparam int PC_W = MAX_PRES;

  logic [PC_W-1:0] preCnt;
  logic [pwm_chan_pkg::PRES_HI:0] presEff;
  logic [PC_W-1:0] mask;

  always_comb begin
    presEff = (int'(presSel) > MAX_PRES) ? (pwm_chan_pkg::PRES_HI+1)'(MAX_PRES) : presSel;
    mask    = ~({PC_W{1'b1}} << presEff);
    tick    = run && ((preCnt & mask) == mask);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     preCnt <= '0;
    else if (run)  preCnt <= preCnt + 1'b1;
    else           preCnt <= '0;
  end
endmodule

// File: rtl/pwm_chan_ctrl.sv
module pwm_chan_ctrl (
  input  logic clk,
  input  logic rstN,
  input  logic chanEn,
  input  logic wrMode,
  input  logic wrPrd,
  input  logic wrDuty,
  input  logic wrPrdUpd,
  input  logic wrDutyUpd,
  input  logic wrSharedUpd,
  input  logic shareTgt,
  output logic running,
  output pwm_chan_pkg::chanStrobe_t strb
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) running <= 1'b0;
    else       running <= chanEn;
  end

  always_comb begin
    strb.loadCfg    = wrMode & ~running;
    strb.loadTgt    = wrMode;
    strb.prdNow     = wrPrd & ~running;
    strb.dutyNow    = wrDuty & ~running;
    strb.prdShadow  = wrPrdUpd | (wrSharedUpd & shareTgt);
    strb.dutyShadow = wrDutyUpd | (wrSharedUpd & ~shareTgt);
  end
endmodule

// File: rtl/pwm_chan_datapath.sv
module pwm_chan_datapath #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             running,
  input  logic             tick,
  input  pwm_chan_pkg::chanStrobe_t strb,
  input  logic [CNT_W-1:0] wrData,
  output logic [pwm_chan_pkg::PRES_HI:0] presSel,
  output logic             shareTgt,
  output logic             pwmOut,
  output logic             periodEnd
);
  import pwm_chan_pkg::*;

  logic [CNT_W-1:0] cnt, prdLive, dutyLive, prdShad, dutyShad;
  logic             prdPend, dutyPend, polReg, tgtReg, wrap, active;
  logic [PRES_HI:0] presReg;

  always_comb begin
    wrap   = tick && (({1'b0, cnt} + (CNT_W+1)'(1)) >= {1'b0, prdLive});
    active = running && (cnt >= dutyLive);
    pwmOut = active ^ polReg;
  end

  assign presSel  = presReg;
  assign shareTgt = tgtReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      presReg <= '0;
      polReg  <= 1'b0;
      tgtReg  <= 1'b0;
    end else begin
      if (strb.loadCfg) begin
        presReg <= wrData[PRES_HI:0];
        polReg  <= wrData[POL_BIT];
      end
      if (strb.loadTgt) tgtReg <= wrData[TGT_BIT];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt       <= '0;
      periodEnd <= 1'b0;
    end else begin
      periodEnd <= wrap;
      if (!running)  cnt <= '0;
      else if (wrap) cnt <= '0;
      else if (tick) cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prdLive  <= '0;
      prdShad  <= '0;
      prdPend  <= 1'b0;
      dutyLive <= '0;
      dutyShad <= '0;
      dutyPend <= 1'b0;
    end else begin
      if (strb.prdNow)            prdLive <= wrData;
      else if (wrap && prdPend)   prdLive <= prdShad;
      if (strb.prdShadow) begin
        prdShad <= wrData;
        prdPend <= 1'b1;
      end else if (wrap) begin
        prdPend <= 1'b0;
      end

      if (strb.dutyNow)           dutyLive <= wrData;
      else if (wrap && dutyPend)  dutyLive <= dutyShad;
      if (strb.dutyShadow) begin
        dutyShad <= wrData;
        dutyPend <= 1'b1;
      end else if (wrap) begin
        dutyPend <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/pwm_chan.sv
module pwm_chan #(
  parameter int CNT_W    = 16,
  parameter int MAX_PRES = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             chanEn,
  input  logic             wrMode,
  input  logic             wrPrd,
  input  logic             wrDuty,
  input  logic             wrPrdUpd,
  input  logic             wrDutyUpd,
  input  logic             wrSharedUpd,
  input  logic [CNT_W-1:0] wrData,
  output logic             pwmOut,
  output logic             running,
  output logic             periodEnd
);
  import pwm_chan_pkg::*;

  chanStrobe_t      strb;
  logic             tick, shareTgt;
  logic [PRES_HI:0] presSel;

  pwm_chan_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .chanEn(chanEn),
    .wrMode(wrMode), .wrPrd(wrPrd), .wrDuty(wrDuty),
    .wrPrdUpd(wrPrdUpd), .wrDutyUpd(wrDutyUpd), .wrSharedUpd(wrSharedUpd),
    .shareTgt(shareTgt), .running(running), .strb(strb)
  );

  pwm_chan_prescale #(.MAX_PRES(MAX_PRES)) u_pre (
    .clk(clk), .rstN(rstN), .run(running), .presSel(presSel), .tick(tick)
  );

  pwm_chan_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .running(running), .tick(tick), .strb(strb),
    .wrData(wrData), .presSel(presSel), .shareTgt(shareTgt),
    .pwmOut(pwmOut), .periodEnd(periodEnd)
  );
endmodule

// File: rtl/pwm_chan_checker.sv
module pwm_chan_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             running,
  input logic             periodEnd,
  input logic             pwmOut,
  input logic             polReg,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] prdLive,
  input logic [CNT_W-1:0] dutyLive
);
  p_end_cnt_zero_r2: assert property (@(posedge clk) disable iff (!rstN)
    periodEnd |-> (cnt == '0));

  p_count_range_r2: assert property (@(posedge clk) disable iff (!rstN)
    (running && prdLive != '0) |-> (cnt < prdLive));

  p_start_inactive_r4: assert property (@(posedge clk) disable iff (!rstN)
    (periodEnd && running && dutyLive != '0) |-> (pwmOut == polReg));

  p_idle_level_r5: assert property (@(posedge clk) disable iff (!rstN)
    !running |-> (pwmOut == polReg));

  p_idle_cnt_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!running && $past(!running)) |-> (cnt == '0));

  p_live_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (running && $past(running) && !periodEnd) |-> ($stable(prdLive) && $stable(dutyLive)));
endmodule

bind pwm_chan pwm_chan_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .running(running), .periodEnd(periodEnd),
  .pwmOut(pwmOut), .polReg(u_dp.polReg), .cnt(u_dp.cnt),
  .prdLive(u_dp.prdLive), .dutyLive(u_dp.dutyLive)
);

// File: tb/pwm_chan_bench.sv
`timescale 1ns/1ps
module pwm_chan_bench;
  localparam int W = 16;

  logic clk = 1'b0, rstN = 1'b0, chanEn = 1'b0;
  logic wrMode = 0, wrPrd = 0, wrDuty = 0, wrPrdUpd = 0, wrDutyUpd = 0, wrSharedUpd = 0;
  logic [W-1:0] wrData = '0;
  logic pwmOut, running, periodEnd;

  int checks = 0, errors = 0, cycles = 0;
  bit done = 0;
  bit curPol = 0;

  always #5 clk = ~clk;

  pwm_chan #(.CNT_W(W)) u_pwm_chan (
    .clk(clk), .rstN(rstN), .chanEn(chanEn), .wrMode(wrMode), .wrPrd(wrPrd),
    .wrDuty(wrDuty), .wrPrdUpd(wrPrdUpd), .wrDutyUpd(wrDutyUpd),
    .wrSharedUpd(wrSharedUpd), .wrData(wrData),
    .pwmOut(pwmOut), .running(running), .periodEnd(periodEnd)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int expLen(input int pres, input int prd);
    int p = (pres > 10) ? 10 : pres;
    return prd << p;
  endfunction

  function automatic int expAct(input int pres, input int prd, input int duty);
    int p = (pres > 10) ? 10 : pres;
    return (duty >= prd) ? 0 : ((prd - duty) << p);
  endfunction

  function automatic logic [W-1:0] modeWord(input int pres, input bit pol, input bit tgt);
    logic [W-1:0] m = '0;
    m[3:0] = 4'(pres);
    m[9]   = pol;
    m[10]  = tgt;
    return m;
  endfunction

  // which: 0 mode, 1 prd, 2 duty, 3 prdUpd, 4 dutyUpd, 5 shared
  task automatic setStrobe(input int which, input logic [W-1:0] d);
    wrData = d;
    case (which)
      0: wrMode = 1;
      1: wrPrd = 1;
      2: wrDuty = 1;
      3: wrPrdUpd = 1;
      4: wrDutyUpd = 1;
      default: wrSharedUpd = 1;
    endcase
  endtask

  task automatic clrStrobes();
    {wrMode, wrPrd, wrDuty, wrPrdUpd, wrDutyUpd, wrSharedUpd} = '0;
  endtask

  task automatic wr(input int which, input logic [W-1:0] d);
    @(negedge clk);
    setStrobe(which, d);
    @(negedge clk);
    clrStrobes();
  endtask

  task automatic cfg(input int pres, input bit pol, input int prd, input int duty);
    @(negedge clk);
    chanEn = 0;
    repeat (2) @(negedge clk);
    wr(0, modeWord(pres, pol, 0));
    wr(1, W'(prd));
    wr(2, W'(duty));
    curPol = pol;
    chanEn = 1;
  endtask

  // Measures one full period starting at a periodEnd pulse; optional write in its first cycle.
  task automatic measure(input bit doWr, input int which, input logic [W-1:0] d,
                         output int len, output int act, output bit startInact);
    int wait_n = 0;
    len = 0; act = 0; startInact = 0;
    @(negedge clk);
    while (!periodEnd && wait_n < 10000) begin
      @(negedge clk);
      wait_n++;
    end
    if (!periodEnd) begin
      chk(0, "R2 timeout waiting for periodEnd", 0, 1);
      return;
    end
    startInact = (pwmOut == curPol);
    len = 1;
    if (pwmOut != curPol) act++;
    if (doWr) setStrobe(which, d);
    forever begin
      @(negedge clk);
      clrStrobes();
      if (periodEnd || len > 10000) break;
      len++;
      if (pwmOut != curPol) act++;
    end
  endtask

  task automatic checkPeriod(input string tag, input int len, input int act, input bit si,
                             input int pres, input int prd, input int duty);
    chk(len == expLen(pres, prd), {tag, " R2 R1 period length"}, len, expLen(pres, prd));
    chk(act == expAct(pres, prd, duty), {tag, " R3 active cycles"}, act, expAct(pres, prd, duty));
    if (duty > 0) chk(si, {tag, " R4 period starts inactive"}, int'(si), 1);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 150000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int len, act;
    bit si;
    void'($urandom(32'd20240611));

    repeat (4) @(negedge clk);
    chk(pwmOut == 0, "R9 reset pwmOut", int'(pwmOut), 0);
    chk(running == 0, "R9 reset running", int'(running), 0);
    chk(periodEnd == 0, "R9 reset periodEnd", int'(periodEnd), 0);
    rstN = 1;

    // R5: stopped channel shows inactive level of chosen polarity
    wr(0, modeWord(0, 1, 0));
    @(negedge clk);
    chk(pwmOut == 1, "R5 idle level with polarity set", int'(pwmOut), 1);
    chk(running == 0, "R5 running low while stopped", int'(running), 0);

    // R1: prescale field above 10 is clamped
    cfg(15, 0, 2, 1);
    measure(0, 0, '0, len, act, si);
    checkPeriod("clamp R1", len, act, si, 15, 2, 1);

    // R3: duty beyond period gives no active time; duty zero is all active
    cfg(1, 1, 5, 7);
    measure(0, 0, '0, len, act, si);
    checkPeriod("dutyover R3", len, act, si, 1, 5, 7);
    cfg(0, 0, 6, 0);
    measure(0, 0, '0, len, act, si);
    checkPeriod("dutyzero R3", len, act, si, 0, 6, 0);

    // R6: duty and period updates wait for the period boundary
    cfg(0, 0, 8, 2);
    measure(1, 4, W'(6), len, act, si);
    checkPeriod("dutyupd-cur R6", len, act, si, 0, 8, 2);
    measure(1, 3, W'(10), len, act, si);
    checkPeriod("dutyupd-next R6", len, act, si, 0, 8, 6);
    measure(0, 0, '0, len, act, si);
    checkPeriod("prdupd-next R6", len, act, si, 0, 10, 6);

    // R8: direct writes ignored while running
    wr(1, W'(3));
    wr(2, W'(1));
    measure(0, 0, '0, len, act, si);
    measure(0, 0, '0, len, act, si);
    checkPeriod("direct-ignored R8", len, act, si, 0, 10, 6);

    // R7: shared update register follows the target bit
    cfg(0, 0, 8, 2);
    measure(1, 5, W'(5), len, act, si);
    checkPeriod("shared-cur R7", len, act, si, 0, 8, 2);
    measure(0, 0, '0, len, act, si);
    checkPeriod("shared-duty R7", len, act, si, 0, 8, 5);
    // bit 10 accepted while running, prescale/polarity bits ignored (R8)
    wr(0, modeWord(2, 1, 1));
    measure(1, 5, W'(6), len, act, si);
    checkPeriod("mode-ignored R8", len, act, si, 0, 8, 5);
    measure(0, 0, '0, len, act, si);
    checkPeriod("shared-prd R7", len, act, si, 0, 6, 5);

    // R5: output back to inactive level after stop
    @(negedge clk);
    chanEn = 0;
    repeat (2) @(negedge clk);
    chk(running == 0, "R5 running drops after disable", int'(running), 0);
    chk(pwmOut == curPol, "R5 idle level after disable", int'(pwmOut), int'(curPol));

    // Random trials
    for (int t = 0; t < 20; t++) begin
      int pr = $urandom_range(3, 0);
      int pd = $urandom_range(12, 2);
      int dt = $urandom_range(pd + 2, 0);
      bit pl = 1'($urandom_range(1, 0));
      cfg(pr, pl, pd, dt);
      measure(0, 0, '0, len, act, si);
      checkPeriod("random", len, act, si, pr, pd, dt);
      chk(running == 1, "R5 running while enabled", int'(running), 1);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule